// File: doc/BRIEF.md
# Double-Precision to Signed Word Converter

This block turns a 64-bit IEEE-754 double into a signed 32-bit integer, the way a floating-point unit's "convert to integer word" operation does. It produces a 64-bit destination pattern, a write strobe for that destination, six status flags and a one-cycle exception request. The integer result sits in the low word of the destination, and a fixed marker fills the upper word. A single result register follows the combinational datapath. An operand presented with `in_valid` high at one rising edge yields its results right after that edge.

The rounding direction comes from a 2-bit field. A separate truncate select forces round-toward-zero no matter what the field holds. The range test is made on the already rounded value.

The block also covers three invalid cases: NaN operands, infinities, and finite values that round outside the signed 32-bit range. Each raises invalid-conversion status. When the invalid-operation enable is clear, the destination receives a fixed saturation pattern. When the enable is set, the write is suppressed and an exception request is raised.

Top module: `dbl_to_word_cvt`

## Requirements
- R1: Results of an operand sampled with `in_valid` high appear at the next rising edge, together with `out_valid`. In any cycle after an edge where `in_valid` was low, `out_valid`, `dest_we` and `exc_req` are 0, and `dest_bits` and all flags keep their values. After reset all outputs are 0.
- R2: A NaN operand (exponent field bits 62:52 all ones, fraction bits 51:0 nonzero) sets `flag_vxcvi` and `flag_vx` and clears `flag_fr` and `flag_fi`. `flag_vxsnan` is 1 exactly when fraction bit 51 (the quiet bit) is 0.
- R3: A finite operand whose rounded value is above 2147483647 or below -2147483648, and any infinity, sets `flag_vxcvi` and `flag_vx` and clears `flag_vxsnan`, `flag_fr` and `flag_fi`.
- R4: On any invalid case of R2 or R3 with `inv_en` = 1, `flag_fex` and `exc_req` are 1, `dest_we` is 0, and `dest_bits` keeps its previous value.
- R5: On any invalid case with `inv_en` = 0, `dest_we` is 1 and `flag_fex` and `exc_req` are 0. A NaN writes 0xFFF8000080000000. An invalid operand with sign bit 63 clear writes 0xFFF800007FFFFFFF, and one with sign bit 63 set writes 0xFFF8000080000000.
- R6: A valid conversion writes {0xFFF80000, two's-complement 32-bit result} with `dest_we` = 1. `flag_vxcvi`, `flag_vxsnan`, `flag_vx`, `flag_fex` and `exc_req` are 0.
- R7: Rounding field `rnd_mode` encodings: 0 = nearest with ties to even, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity.
- R8: With `force_trunc` = 1, the conversion rounds toward zero whatever `rnd_mode` holds.
- R9: For a valid conversion, `flag_fi` = 1 when the result differs from the operand. `flag_fr` = 1 when the magnitude of the result exceeds the magnitude of the operand.
- R10: Zeros of either sign convert to 0 with `flag_fi` = 0. Nonzero denormals are treated as magnitudes below one half, so they give 0, or ±1 under a directed mode, with `flag_fi` = 1.
- R11: The range test follows rounding. For example, 2147483647.25 rounds to 0x7FFFFFFF without error under mode 0. 2147483647.5 under mode 0 is invalid. -2147483648.5 under mode 0 gives 0x80000000, but under mode 3 it is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand and controls are valid this cycle |
| op_bits | input | 64 | Double-precision operand bit pattern |
| rnd_mode | input | 2 | Rounding field (R7) |
| force_trunc | input | 1 | Forces round toward zero |
| inv_en | input | 1 | Invalid-operation exception enable |
| out_valid | output | 1 | Results below belong to a new operand |
| dest_bits | output | 64 | Destination pattern |
| dest_we | output | 1 | Destination write strobe |
| flag_vxcvi | output | 1 | Invalid integer conversion |
| flag_vxsnan | output | 1 | Signaling NaN operand |
| flag_vx | output | 1 | Invalid-operation summary |
| flag_fex | output | 1 | Enabled exception summary |
| flag_fr | output | 1 | Magnitude rounded up |
| flag_fi | output | 1 | Result inexact |
| exc_req | output | 1 | Exception request pulse |

## Verification
Every result is due exactly one rising edge after the edge that samples `in_valid` high, and all results of an operand arrive together in that one cycle. The bench applies each operand at a falling edge and compares the whole output vector at the following falling edge, half a period after the edge that loads the result register. For specials it waits one more falling edge with `in_valid` low and checks that the strobes have dropped while the destination and the flags stay as they were. The sweeps cover eighths of a unit around zero and around both range limits, plus NaNs, infinities, zeros and denormals. Each operand runs under all four rounding codes, both truncate settings and both enable settings.

// File: rtl/cvt_pkg.sv
package cvt_pkg;

  typedef enum logic [1:0] {
    RND_NEAREST = 2'd0,
    RND_ZERO    = 2'd1,
    RND_UP      = 2'd2,
    RND_DOWN    = 2'd3
  } rnd_e;

  typedef struct packed {
    logic sign;
    logic is_nan;
    logic is_snan;
    logic is_inf;
    logic is_zero;
    logic is_sub;
    logic is_norm;
  } opclass_t;

  // Effective rounding direction: truncation overrides the field.
  function automatic rnd_e pick_mode(input logic [1:0] field, input logic trunc);
    return trunc ? RND_ZERO : rnd_e'(field);
  endfunction

  // Decide whether the truncated magnitude must be incremented.
  function automatic logic round_up(input rnd_e mode, input logic sign,
                                    input logic lsb, input logic rbit,
                                    input logic sticky);
    logic lost;
    lost = rbit | sticky;
    unique case (mode)
      RND_NEAREST: return rbit & (sticky | lsb);
      RND_ZERO:    return 1'b0;
      RND_UP:      return lost & ~sign;
      RND_DOWN:    return lost & sign;
      default:     return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cvt_classify.sv
module cvt_classify
  import cvt_pkg::*;
#(
  parameter int EXPW = 11,
  parameter int MANW = 52
) (
  input  logic [EXPW+MANW:0] op,
  output opclass_t           cls,
  output logic [EXPW-1:0]    exp_f,
  output logic [MANW-1:0]    man_f
);
  logic exp_max, exp_min, man_nz;

  assign exp_f   = op[EXPW+MANW-1:MANW];
  assign man_f   = op[MANW-1:0];
  assign exp_max = &exp_f;
  assign exp_min = ~|exp_f;
  assign man_nz  = |man_f;

  always_comb begin
    cls.sign    = op[EXPW+MANW];
    cls.is_nan  = exp_max & man_nz;
    cls.is_snan = exp_max & man_nz & ~man_f[MANW-1];
    cls.is_inf  = exp_max & ~man_nz;
    cls.is_zero = exp_min & ~man_nz;
    cls.is_sub  = exp_min & man_nz;
    cls.is_norm = ~exp_max & ~exp_min;
  end
endmodule

// File: rtl/cvt_align.sv
module cvt_align #(
  parameter int EXPW = 11,
  parameter int MANW = 52,
  parameter int IW   = 32
) (
  input  logic            norm,
  input  logic            sub,
  input  logic [EXPW-1:0] exp_f,
  input  logic [MANW-1:0] man_f,
  output logic [IW:0]     int_mag,
  output logic            rbit,
  output logic            sticky,
  output logic            huge
);
  localparam int BIAS = (1 << (EXPW - 1)) - 1;
  localparam int SIGW = MANW + 1;
  localparam int WW   = SIGW + 2;
  localparam logic [WW-1:0] ONE_WW = {{(WW-1){1'b0}}, 1'b1};

  int             ue;
  int             sh;
  logic [WW-1:0]  sig_w;
  logic [WW-1:0]  shifted;
  logic [WW-1:0]  lowmask;

  always_comb begin
    ue      = int'(exp_f) - BIAS;
    sh      = MANW - ue;
    sig_w   = {2'b00, 1'b1, man_f};
    shifted = '0;
    lowmask = '0;
    int_mag = '0;
    rbit    = 1'b0;
    sticky  = 1'b0;
    huge    = 1'b0;
    if (sub) begin
      sticky = |man_f;
    end else if (norm) begin
      if (ue > IW) begin
        huge = 1'b1;
      end else if (ue < -1) begin
        sticky = 1'b1;
      end else begin
        shifted = sig_w >> sh;
        int_mag = shifted[IW:0];
        shifted = sig_w >> (sh - 1);
        rbit    = shifted[0];
        lowmask = (ONE_WW << (sh - 1)) - ONE_WW;
        sticky  = |(sig_w & lowmask);
      end
    end
  end
endmodule

// File: rtl/cvt_round.sv
module cvt_round
  import cvt_pkg::*;
#(
  parameter int IW = 32
) (
  input  rnd_e          mode,
  input  logic          sign,
  input  logic          huge,
  input  logic [IW:0]   mag,
  input  logic          rbit,
  input  logic          sticky,
  output logic [IW-1:0] word,
  output logic          ovf,
  output logic          inexact,
  output logic          rndup
);
  localparam logic [IW+1:0] POS_MAX = {3'b000, {(IW-1){1'b1}}};
  localparam logic [IW+1:0] NEG_MAX = {3'b001, {(IW-1){1'b0}}};
  localparam logic [IW-1:0] ONE_W   = {{(IW-1){1'b0}}, 1'b1};

  logic [IW+1:0] mag_r;

  always_comb begin
    rndup   = round_up(mode, sign, mag[0], rbit, sticky);
    inexact = rbit | sticky;
    mag_r   = {1'b0, mag} + {{(IW+1){1'b0}}, rndup};
    ovf     = huge | (sign ? (mag_r > NEG_MAX) : (mag_r > POS_MAX));
    word    = sign ? (~mag_r[IW-1:0] + ONE_W) : mag_r[IW-1:0];
  end
endmodule

// File: rtl/dbl_to_word_cvt.sv
module dbl_to_word_cvt
  import cvt_pkg::*;
#(
  parameter int DW   = 64,
  parameter int EXPW = 11,
  parameter int IW   = 32,
  parameter logic [DW-IW-1:0] UPPER_TAG = 32'hFFF80000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] op_bits,
  input  logic [1:0]    rnd_mode,
  input  logic          force_trunc,
  input  logic          inv_en,
  output logic          out_valid,
  output logic [DW-1:0] dest_bits,
  output logic          dest_we,
  output logic          flag_vxcvi,
  output logic          flag_vxsnan,
  output logic          flag_vx,
  output logic          flag_fex,
  output logic          flag_fr,
  output logic          flag_fi,
  output logic          exc_req
);
  localparam int MANW = DW - 1 - EXPW;
  localparam logic [IW-1:0] POS_SAT = {1'b0, {(IW-1){1'b1}}};
  localparam logic [IW-1:0] NEG_SAT = {1'b1, {(IW-1){1'b0}}};

  opclass_t        cls;
  logic [EXPW-1:0] exp_f;
  logic [MANW-1:0] man_f;
  logic [IW:0]     int_mag;
  logic            rbit, sticky, huge;
  rnd_e            eff_mode;
  logic [IW-1:0]   word;
  logic            rnd_ovf, rnd_inexact, rnd_up;

  // Named internal events, observed by the bound checker.
  logic            ev_nan, ev_snan, ev_ovf, ev_invalid, ev_trap;
  logic [DW-1:0]   next_dest;

  cvt_classify #(.EXPW(EXPW), .MANW(MANW)) u_cls (
    .op    (op_bits),
    .cls   (cls),
    .exp_f (exp_f),
    .man_f (man_f)
  );

  cvt_align #(.EXPW(EXPW), .MANW(MANW), .IW(IW)) u_aln (
    .norm    (cls.is_norm),
    .sub     (cls.is_sub),
    .exp_f   (exp_f),
    .man_f   (man_f),
    .int_mag (int_mag),
    .rbit    (rbit),
    .sticky  (sticky),
    .huge    (huge)
  );

  assign eff_mode = pick_mode(rnd_mode, force_trunc);

  cvt_round #(.IW(IW)) u_rnd (
    .mode    (eff_mode),
    .sign    (cls.sign),
    .huge    (huge),
    .mag     (int_mag),
    .rbit    (rbit),
    .sticky  (sticky),
    .word    (word),
    .ovf     (rnd_ovf),
    .inexact (rnd_inexact),
    .rndup   (rnd_up)
  );

  assign ev_nan     = cls.is_nan;
  assign ev_snan    = cls.is_snan;
  assign ev_ovf     = cls.is_inf | (~cls.is_nan & rnd_ovf);
  assign ev_invalid = ev_nan | ev_ovf;
  assign ev_trap    = ev_invalid & inv_en;

  always_comb begin
    if (ev_nan)      next_dest = {UPPER_TAG, NEG_SAT};
    else if (ev_ovf) next_dest = {UPPER_TAG, cls.sign ? NEG_SAT : POS_SAT};
    else             next_dest = {UPPER_TAG, word};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      dest_bits   <= '0;
      dest_we     <= 1'b0;
      flag_vxcvi  <= 1'b0;
      flag_vxsnan <= 1'b0;
      flag_vx     <= 1'b0;
      flag_fex    <= 1'b0;
      flag_fr     <= 1'b0;
      flag_fi     <= 1'b0;
      exc_req     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      dest_we   <= in_valid & ~ev_trap;
      exc_req   <= in_valid & ev_trap;
      if (in_valid) begin
        flag_vxcvi  <= ev_invalid;
        flag_vx     <= ev_invalid;
        flag_vxsnan <= ev_snan;
        flag_fex    <= ev_trap;
        flag_fr     <= ~ev_invalid & rnd_up;
        flag_fi     <= ~ev_invalid & rnd_inexact;
        if (!ev_trap) dest_bits <= next_dest;
      end
    end
  end
endmodule

// File: rtl/cvt_checker.sv
module cvt_checker #(
  parameter int DW = 64,
  parameter int IW = 32,
  parameter logic [DW-IW-1:0] UPPER_TAG = 32'hFFF80000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          inv_en,
  input logic          ev_nan,
  input logic          ev_snan,
  input logic          ev_invalid,
  input logic          ev_trap,
  input logic          out_valid,
  input logic [DW-1:0] dest_bits,
  input logic          dest_we,
  input logic          flag_vxcvi,
  input logic          flag_vxsnan,
  input logic          flag_vx,
  input logic          flag_fex,
  input logic          flag_fr,
  input logic          flag_fi,
  input logic          exc_req
);
  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!dest_we && !exc_req));

  assert_nan_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ev_nan) |=> (flag_vxcvi && flag_vx && !flag_fr && !flag_fi
                              && (flag_vxsnan == $past(ev_snan))));

  assert_snan_implies_vx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_vxsnan) |-> (flag_vxcvi && flag_vx));

  assert_invalid_clears_round_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_vxcvi) |-> (!flag_fr && !flag_fi));

  assert_trap_blocks_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ev_trap) |=> (exc_req && flag_fex && !dest_we && $stable(dest_bits)));

  assert_masked_invalid_writes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ev_invalid && !inv_en) |=> (dest_we && !flag_fex && !exc_req));

  assert_valid_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !ev_invalid) |=> (dest_we && !flag_vx && !flag_vxcvi && !flag_fex && !exc_req));

  assert_upper_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && dest_we) |-> (dest_bits[DW-1:IW] == UPPER_TAG));

  assert_fr_needs_fi_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_fr) |-> flag_fi);
endmodule

bind dbl_to_word_cvt cvt_checker #(.DW(DW), .IW(IW), .UPPER_TAG(UPPER_TAG)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .inv_en      (inv_en),
  .ev_nan      (ev_nan),
  .ev_snan     (ev_snan),
  .ev_invalid  (ev_invalid),
  .ev_trap     (ev_trap),
  .out_valid   (out_valid),
  .dest_bits   (dest_bits),
  .dest_we     (dest_we),
  .flag_vxcvi  (flag_vxcvi),
  .flag_vxsnan (flag_vxsnan),
  .flag_vx     (flag_vx),
  .flag_fex    (flag_fex),
  .flag_fr     (flag_fr),
  .flag_fi     (flag_fi),
  .exc_req     (exc_req)
);

// File: tb/dbl_to_word_cvt_tb.sv
`timescale 1ns/1ps
module dbl_to_word_cvt_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] op_bits = '0;
  logic [1:0]  rnd_mode = '0;
  logic        force_trunc = 1'b0;
  logic        inv_en = 1'b0;
  logic        out_valid, dest_we, exc_req;
  logic [63:0] dest_bits;
  logic        flag_vxcvi, flag_vxsnan, flag_vx, flag_fex, flag_fr, flag_fi;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;
  logic [72:0] last_ev = '0;

  always #2 clk = ~clk;

  dbl_to_word_cvt u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_bits(op_bits),
    .rnd_mode(rnd_mode), .force_trunc(force_trunc), .inv_en(inv_en),
    .out_valid(out_valid), .dest_bits(dest_bits), .dest_we(dest_we),
    .flag_vxcvi(flag_vxcvi), .flag_vxsnan(flag_vxsnan), .flag_vx(flag_vx),
    .flag_fex(flag_fex), .flag_fr(flag_fr), .flag_fi(flag_fi), .exc_req(exc_req)
  );

  // {out_valid, dest_we, exc_req, vxcvi, vxsnan, vx, fex, fr, fi, dest[63:0]}
  function automatic logic [72:0] observed();
    return {out_valid, dest_we, exc_req, flag_vxcvi, flag_vxsnan, flag_vx,
            flag_fex, flag_fr, flag_fi, dest_bits};
  endfunction

  function automatic logic [72:0] predict(input logic [63:0] b, input logic [1:0] md,
                                          input bit tr, input bit en,
                                          input logic [63:0] prev_dest);
    real v, fl, fr_, r, av, ar;
    bit nan, snan, inf, inv, fi, fr;
    int m, iw;
    logic [63:0] d;
    m    = tr ? 1 : int'(md);
    nan  = (b[62:52] == 11'h7FF) && (b[51:0] != 0);
    snan = nan && !b[51];
    inf  = (b[62:52] == 11'h7FF) && (b[51:0] == 0);
    inv = nan || inf;
    fi = 0; fr = 0; d = '0;
    if (!inv) begin
      v   = $bitstoreal(b);
      fl  = $floor(v);
      fr_ = v - fl;
      case (m)
        0: begin
          if (fr_ > 0.5) r = fl + 1.0;
          else if (fr_ < 0.5) r = fl;
          else r = ((longint'(fl) % 2) == 0) ? fl : fl + 1.0;
        end
        1: r = (v >= 0.0) ? fl : ((fr_ > 0.0) ? fl + 1.0 : fl);
        2: r = (fr_ > 0.0) ? fl + 1.0 : fl;
        default: r = fl;
      endcase
      inv = (r > 2147483647.0) || (r < -2147483648.0);
      if (!inv) begin
        iw = $rtoi(r);
        d  = {32'hFFF80000, iw[31:0]};
        av = (v < 0.0) ? -v : v;
        ar = (r < 0.0) ? -r : r;
        fi = (r != v);
        fr = (ar > av);
      end
    end
    if (inv) begin
      if (en) d = prev_dest;
      else if (nan) d = 64'hFFF8000080000000;
      else d = b[63] ? 64'hFFF8000080000000 : 64'hFFF800007FFFFFFF;
      return {1'b1, !en, en, 1'b1, snan, 1'b1, en, 1'b0, 1'b0, d};
    end
    return {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, fr, fi, d};
  endfunction

  task automatic run_op(input logic [63:0] b, input logic [1:0] md, input bit tr,
                        input bit en, input string tag);
    logic [72:0] ev, act;
    string t;
    ev = predict(b, md, tr, en, last_ev[63:0]);
    t = tag;
    if (tr) t = {t, " R8"};
    if (ev[69]) t = {t, en ? " R4" : " R5"};
    @(negedge clk);
    op_bits = b; rnd_mode = md; force_trunc = tr; inv_en = en; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    act = observed();
    n_chk++;
    if (act !== ev) begin
      n_err++;
      $display("FAIL %s op=%h mode=%0d trunc=%0b en=%0b actual=%h expected=%h",
               t, b, md, tr, en, act, ev);
    end
    last_ev = ev;
  endtask

  // R1: one idle cycle later, strobes drop and results stay.
  task automatic hold_check();
    logic [72:0] ev, act;
    ev = {3'b000, last_ev[69:0]};
    @(negedge clk);
    act = observed();
    n_chk++;
    if (act !== ev) begin
      n_err++;
      $display("FAIL R1 hold actual=%h expected=%h", act, ev);
    end
  endtask

  task automatic sweep(input logic [63:0] b, input string tag, input bit hold);
    for (int md = 0; md < 4; md++)
      for (int tr = 0; tr < 2; tr++)
        for (int en = 0; en < 2; en++) begin
          run_op(b, md[1:0], tr[0], en[0], tag);
          if (hold) hold_check();
        end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_err++;
      n_chk++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (observed() !== 73'd0) begin
      n_err++;
      $display("FAIL R1 reset actual=%h expected=%h", observed(), 73'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R6 R7 R9: eighths around zero, ties included
    for (int i = -40; i <= 40; i++)
      sweep($realtobits(i * 0.125), "R6 R7 R9", 1'b0);

    // R3 R11: around the upper and lower limits
    for (int j = -8; j <= 8; j++) begin
      sweep($realtobits(2147483647.0 + j * 0.125), "R3 R11", 1'b0);
      sweep($realtobits(-2147483648.0 + j * 0.125), "R3 R11", 1'b0);
    end

    // R2: quiet and signaling NaNs of both signs
    sweep(64'h7FF8000000000001, "R2", 1'b1);
    sweep(64'h7FF0000000000001, "R2", 1'b1);
    sweep(64'hFFF8000000000000, "R2", 1'b1);
    sweep(64'hFFF4000000000000, "R2", 1'b1);
    // R3: infinities and far out-of-range values
    sweep(64'h7FF0000000000000, "R3", 1'b1);
    sweep(64'hFFF0000000000000, "R3", 1'b1);
    sweep($realtobits(1.0e300), "R3", 1'b1);
    sweep($realtobits(-1.0e300), "R3", 1'b1);
    sweep($realtobits(4294967296.5), "R3", 1'b1);
    // R10: zeros and denormals
    sweep(64'h0000000000000000, "R10", 1'b1);
    sweep(64'h8000000000000000, "R10", 1'b1);
    sweep(64'h0000000000000001, "R10", 1'b1);
    sweep(64'h8000000000000001, "R10", 1'b1);
    sweep(64'h000FFFFFFFFFFFFF, "R10", 1'b1);
    // R6 R9: large in-range values with fractions
    sweep($realtobits(123456789.75), "R6 R9", 1'b1);
    sweep($realtobits(-98765.5), "R6 R7", 1'b1);
    sweep($realtobits(0.0000001), "R9", 1'b1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule